// File: doc/BRIEF.md
# FIFO with Marked-Word Retransmit

This block is a single-clock first-in, first-out buffer of 512 words of 32 bits. On top of plain queueing it can replay stored data. Raising the retransmit enable records the current read position as the start of a replay vector. A rewind pulse then moves the read pointer back to that word, so the same vector can be read out again as often as needed. Conventional replay always restarts at address zero; here the start is wherever reading stood when the mode was entered.

While retransmit is enabled, the words from the marked start up to the read pointer stay reserved, and the writer cannot overwrite them. Fullness is therefore measured from the marked word rather than from the read pointer. Dropping the enable ends the mode: the reserved words become free space and fullness is again measured from the read pointer. A typical use is a coefficient store for a filter loop. Coefficients are written once, the loop marks the first one, and it rewinds after every pass.

Top module: `rt_fifo`

## Requirements
- R1: After reset `empty` is 1, `full` is 0 and `rd_data` is zero.
- R2: Words are read out in the order they were written. An accepted read (`rd_en` high, `empty` low) places the word on `rd_data` after that clock edge.
- R3: While `full` is 1 a write is dropped and stored data is unchanged.
- R4: A read while `empty` is 1 is dropped and `rd_data` keeps its value.
- R5: In the cycle where `rt_en` is first seen high, the word at the current read position becomes the marked start.
- R6: A rewind pulse in retransmit mode moves the read pointer to the marked start at the next edge. The following read returns the marked word, and this can be repeated any number of times.
- R7: In retransmit mode `full` rises when 512 words are held counting from the marked start. Words between the marked start and the read pointer are never overwritten.
- R8: A rewind is ignored while fewer than 3 words have been written since the marked start.
- R9: A rewind is ignored while `rt_en` is low.
- R10: Once `rt_en` drops, words before the read pointer are released, and `full` is computed from the read pointer.
- R11: When a valid rewind and a read request fall in the same cycle, the rewind wins. The read is discarded and `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Word to store |
| full | output | 1 | No room for another write |
| rd_en | input | 1 | Read request |
| rd_data | output | 32 | Last word read, registered |
| empty | output | 1 | No unread word |
| rt_en | input | 1 | Retransmit mode enable, level; its rising edge marks the start |
| rt_rewind | input | 1 | Return the read pointer to the marked start |

## Verification
A valid rewind and a read request can land on the same edge, and the block has to pick one. The bench raises both strobes in one cycle after a replay has already moved the output. It expects the output word to stay unchanged in that cycle, and the next plain read to return the marked word. If the read had slipped through, the held value would change and the later read would be one word late.

// File: rtl/rt_fifo.sv
module rt_fifo #(
  parameter int WIDTH   = 32,
  parameter int DEPTH   = 512,
  parameter int MIN_VEC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  input  logic             rt_en,
  input  logic             rt_rewind
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = DEPTH[AW:0];
  localparam logic [AW:0] MIN_CNT  = MIN_VEC[AW:0];

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wr_ptr, rd_ptr, mark_ptr;
  logic        mode_q;

  wire [AW:0] used_rd   = wr_ptr - rd_ptr;
  wire [AW:0] used_hold = wr_ptr - mark_ptr;
  wire        rewind_ok = mode_q & rt_en & rt_rewind & (used_hold >= MIN_CNT);

  assign empty = (used_rd == '0);
  assign full  = ((mode_q ? used_hold : used_rd) == FULL_CNT);

  wire do_wr = wr_en & ~full;
  wire do_rd = rd_en & ~empty & ~rewind_ok;

  always_ff @(posedge clk)
    if (do_wr) mem[wr_ptr[AW-1:0]] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      mark_ptr <= '0;
      mode_q   <= 1'b0;
      rd_data  <= '0;
    end else begin
      mode_q <= rt_en;
      if (rt_en && !mode_q) mark_ptr <= rd_ptr;
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (rewind_ok) rd_ptr <= mark_ptr;
      else if (do_rd) begin
        rd_ptr  <= rd_ptr + 1'b1;
        rd_data <= mem[rd_ptr[AW-1:0]];
      end
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en) |=> wr_ptr == $past(wr_ptr));
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en) |=> $stable(rd_data));
  p_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_en && !mode_q) |=> mark_ptr == $past(rd_ptr));
  p_rewind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_ok |=> rd_ptr == $past(mark_ptr));
  p_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (used_hold <= FULL_CNT && (rd_ptr - mark_ptr) <= used_hold));
  p_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_rewind && !rd_en && used_hold < MIN_CNT) |=> $stable(rd_ptr));
  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_rewind && !rt_en && !rd_en) |=> $stable(rd_ptr));
  p_collide_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind_ok && rd_en) |=> $stable(rd_data));
endmodule

// File: tb/test_rt_fifo.sv
module test_rt_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, rt_en = 1'b0, rt_rewind = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        full, empty;

  int tests = 0, fails = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  rt_fifo i_rt_fifo (.clk, .rst_n, .wr_en, .wr_data, .full, .rd_en,
                     .rd_data, .empty, .rt_en, .rt_rewind);

  always #10 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0;
  endtask

  task automatic rd_exp(logic [31:0] v, string tag);
    rd_en = 1'b1; exp_q.push_back(v); tag_q.push_back(tag); step(); rd_en = 1'b0;
  endtask

  task automatic rewind();
    rt_rewind = 1'b1; step(); rt_rewind = 1'b0;
  endtask

  initial forever begin
    @(posedge clk); #5;
    while (exp_q.size() > 0) check(tag_q.pop_front(), rd_data, exp_q.pop_front());
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 empty", 32'(empty), 1);
    check("R1 full", 32'(full), 0);
    check("R1 rd_data", rd_data, 0);
    rst_n = 1'b1; step();

    for (int i = 0; i < 5; i++) wr(100 + i);
    rd_exp(100, "R2 first");
    rd_exp(101, "R2 second");

    rt_en = 1'b1; step();
    rd_exp(102, "R5 marked word");
    rd_exp(103, "R2 third");
    rd_exp(104, "R2 fourth");
    check("R4 empty flag", 32'(empty), 1);
    rd_exp(104, "R4 read on empty holds");
    rewind();
    rd_exp(102, "R6 first replay");
    rd_exp(103, "R6 replay next");
    rewind();
    rd_exp(102, "R6 second replay");

    rd_en = 1'b1; rt_rewind = 1'b1;
    exp_q.push_back(102); tag_q.push_back("R11 collide holds");
    step(); rd_en = 1'b0; rt_rewind = 1'b0;
    rd_exp(102, "R11 rewind won");

    for (int i = 0; i < 509; i++) wr(200 + i);
    check("R7 full from mark", 32'(full), 1);
    wr(32'hDEAD_BEEF);
    check("R3 still full", 32'(full), 1);
    rewind();
    rd_exp(102, "R7 protected word 0");
    rd_exp(103, "R7 protected word 1");
    rd_exp(104, "R7 protected word 2");

    rt_en = 1'b0; step();
    check("R10 full released", 32'(full), 0);
    rewind();
    rd_exp(200, "R9 rewind ignored");
    for (int i = 1; i < 509; i++) rd_exp(200 + i, "R2 drain");
    check("R3 dropped write absent", 32'(empty), 1);

    rt_en = 1'b1; step();
    wr(900); wr(901);
    rd_exp(900, "R8 first");
    rewind();
    rd_exp(901, "R8 short rewind ignored");
    wr(902);
    rewind();
    rd_exp(900, "R6 rewind after third word");
    rt_en = 1'b0; step();
    step();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule